// File: doc/BRIEF.md
# Folded Column Shift Memory

A word-addressed storage block that offers ordinary reads and writes plus a one-word shift of any contiguous address range. A shift names an insert address, a delete address and a new word. Every word lying between the two addresses slides one position toward the delete address. The old word at the delete address is lost, and the new word lands at the insert address. This gives software a fast way to insert into, or remove from, a sorted array without copying the words one at a time.

Storage is divided into columns of `WORDS_PER_COL` words, chained end to end in address order. A shift runs as column-parallel steps in a fixed order. First the delete-address column shifts, then every column strictly between the two end columns shifts in one step, and last the insert-address column shifts and takes the new word. At each column edge one word crosses in from the neighbouring column. The step count depends only on how many columns apart the two addresses are, and never on the length of the range.

Top module: `fold_shift_mem`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low and every word reads as zero.
- R2: A read accepted at a clock edge returns the word at `addr` on `rd_data`, with `rd_valid` high for exactly the next cycle. Operation codes on `cmd_op`: 0 read, 1 write, 2 shift, 3 no operation.
- R3: An accepted write stores `wdata` at `addr`, and no other word changes.
- R4: A shift with `addr` (insert) below `del_addr` moves each word at positions insert to delete-1 up by one address. The old word at delete is lost, `wdata` ends at insert, and words outside the range are unchanged.
- R5: A shift with insert above delete moves each word at positions delete+1 to insert down by one address. The old word at delete is lost, `wdata` ends at insert, and words outside the range are unchanged.
- R6: A shift with insert equal to delete acts as a plain write of `wdata`, and `busy` is never asserted.
- R7: A column is address divided by `WORDS_PER_COL`. After an accepted shift with distinct addresses, `busy` is high for exactly 1 cycle when both addresses share a column, 2 cycles when the columns are adjacent, and 3 cycles otherwise.
- R8: A command presented while `busy` is high is ignored and changes no stored word.
- R9: The shift steps run in this order: delete column, then the middle columns, then the insert column with the write of the new word. The insert step is always last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 read, 1 write, 2 shift, 3 none |
| addr | input | AW | Read/write address, or insert address for a shift |
| del_addr | input | AW | Delete address for a shift |
| wdata | input | DW | Write data, or new word for a shift |
| busy | output | 1 | Shift in progress; commands are ignored |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |

## Verification
The bench shifts every ordered pair of insert and delete addresses over a four-by-four array. This covers ranges that begin or end exactly on column edges, ranges of length one, and the equal-address case. Each time it compares the whole memory against a flat reference model. If the step order were wrong, the crossing word at a column edge would come from a column that had already moved, and that word would be duplicated or lost. If the range limits were off by one, the word at delete or at insert±1 would be corrupted. A command that sneaks in during a shift would leave a stray 0xA5 in memory. The bench also times `busy` against the step count each column distance calls for, so an extra or skipped step is caught.

// File: rtl/fold_shift_mem.sv
module fold_shift_mem #(
  parameter int DW            = 8,
  parameter int WORDS_PER_COL = 4,
  parameter int NCOL          = 4,
  localparam int DEPTH = WORDS_PER_COL * NCOL,
  localparam int AW    = $clog2(DEPTH),
  localparam int CB    = $clog2(WORDS_PER_COL),
  localparam int CLW   = AW - CB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] del_addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  typedef enum logic [1:0] {S_IDLE, S_DEL, S_MID, S_INS} st_t;

  st_t            st;
  logic [DW-1:0]  mem [DEPTH];
  logic [DW-1:0]  from_lo [DEPTH];
  logic [DW-1:0]  from_hi [DEPTH];
  logic [AW-1:0]  ins_q, del_q;
  logic [DW-1:0]  nw_q;
  logic           up_q;
  logic [CLW-1:0] ci_q, cd_q, gap_q;

  wire accept   = cmd_valid && (st == S_IDLE);
  wire do_rd    = accept && cmd_op == 2'd0;
  wire do_wr    = accept && (cmd_op == 2'd1 || (cmd_op == 2'd2 && addr == del_addr));
  wire do_sh    = accept && cmd_op == 2'd2 && addr != del_addr;
  wire up_in    = addr < del_addr;
  wire [CLW-1:0] ci_in  = addr[AW-1:CB];
  wire [CLW-1:0] cd_in  = del_addr[AW-1:CB];
  wire [CLW-1:0] gap_in = up_in ? cd_in - ci_in : ci_in - cd_in;

  assign busy = (st != S_IDLE);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_nbr
      if (g == 0) begin : g_lo0
        assign from_lo[g] = '0;
      end else begin : g_lo
        assign from_lo[g] = mem[g-1];
      end
      if (g == DEPTH-1) begin : g_hiN
        assign from_hi[g] = '0;
      end else begin : g_hi
        assign from_hi[g] = mem[g+1];
      end
    end
  endgenerate

  function automatic logic col_active(input int c);
    int ci, cd;
    ci = int'(ci_q);
    cd = int'(cd_q);
    case (st)
      S_DEL:   col_active = (c == cd);
      S_MID:   col_active = up_q ? (c > ci && c < cd) : (c < ci && c > cd);
      S_INS:   col_active = (c == ci);
      default: col_active = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ins_q <= '0;
      del_q <= '0;
      nw_q  <= '0;
      up_q  <= 1'b0;
      ci_q  <= '0;
      cd_q  <= '0;
      gap_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (do_sh) begin
          ins_q <= addr;
          del_q <= del_addr;
          nw_q  <= wdata;
          up_q  <= up_in;
          ci_q  <= ci_in;
          cd_q  <= cd_in;
          gap_q <= gap_in;
          st    <= (gap_in == '0) ? S_INS : S_DEL;
        end
        S_DEL:   st <= (gap_q == CLW'(1)) ? S_INS : S_MID;
        S_MID:   st <= S_INS;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_wr) begin
      mem[addr] <= wdata;
    end else if (busy) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (col_active(i >> CB)) begin
          if (up_q && i > int'(ins_q) && i <= int'(del_q)) mem[i] <= from_lo[i];
          if (!up_q && i >= int'(del_q) && i < int'(ins_q)) mem[i] <= from_hi[i];
          if (st == S_INS && i == int'(ins_q)) mem[i] <= nw_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= mem[addr];
    end
  end

  logic [1:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 2'd1 : 2'd0;
  end

  p_busy_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < 2'd3);
  p_eq_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd2 && addr == del_addr) |=> !busy);
  p_mid_after_del_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MID) |-> $past(st) == S_DEL);
  p_ins_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INS) |=> !busy);
  p_rd_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !busy && cmd_op == 2'd0));
  p_shift_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd2 && addr != del_addr) |=> busy);
endmodule

// File: tb/fold_shift_mem_tb.sv
module fold_shift_mem_tb_top;
  localparam int DW = 8, CW = 4, NC = 4, DEPTH = CW * NC, AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd3;
  logic [AW-1:0] addr = '0, del_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, rd_valid;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  fold_shift_mem #(.DW(DW), .WORDS_PER_COL(CW), .NCOL(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .addr(addr), .del_addr(del_addr), .wdata(wdata),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic read_check(input int a, input int exp, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; addr = AW'(a);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    check({req, " rd_valid"}, int'(rd_valid), 1);
    check(req, int'(rd_data), exp);
    @(negedge clk);
    check("R2 rd_valid one cycle", int'(rd_valid), 0);
  endtask

  task automatic do_shift(input int ins, input int del, input int nw, output int cycles);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; addr = AW'(ins); del_addr = AW'(del); wdata = DW'(nw);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    cycles = 0;
    while (busy && cycles < 10) begin
      if (cycles == 0) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; addr = AW'(ins); wdata = 8'hA5;
      end else begin
        cmd_valid = 1'b0; cmd_op = 2'd3;
      end
      cycles++;
      @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 rd_valid after reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) read_check(a, 0, "R1 reset contents");

    for (int a = 0; a < DEPTH; a++) do_write(a, 16 * a + 3);
    for (int a = 0; a < DEPTH; a++) read_check(a, (16 * a + 3) & 8'hFF, "R3 write/R2 read");

    for (int ins = 0; ins < DEPTH; ins++) begin
      for (int del = 0; del < DEPTH; del++) begin
        int cyc, expc, gap, nw;
        string req;
        for (int a = 0; a < DEPTH; a++) begin
          model[a] = DW'((a * 5 + ins * 3 + del) & 8'h7F);
          do_write(a, int'(model[a]));
        end
        nw = 8'hC0 | ins;
        do_shift(ins, del, nw, cyc);
        gap = (ins / CW > del / CW) ? ins / CW - del / CW : del / CW - ins / CW;
        expc = (ins == del) ? 0 : (gap == 0) ? 1 : (gap == 1) ? 2 : 3;
        check(ins == del ? "R6 no busy on equal addresses" : "R7 busy step count", cyc, expc);
        if (ins < del) begin
          for (int a = del; a > ins; a--) model[a] = model[a-1];
          req = "R4 up shift (R8 ignored cmd)";
        end else if (ins > del) begin
          for (int a = del; a < ins; a++) model[a] = model[a+1];
          req = "R5 down shift (R8 ignored cmd)";
        end else begin
          req = "R6 equal addresses plain write";
        end
        model[ins] = DW'(nw);
        for (int a = 0; a < DEPTH; a++) read_check(a, int'(model[a]), req);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule